// File: doc/BRIEF.md
# Command-Block I/O Transfer Engine

This block runs data transfers between one peripheral and system memory so that the host does not handle each word. The host launches it with a single start pulse that names a host-level operation, the peripheral to talk to, and the base address of a command block held in memory. The engine then reads that four-word block, one bus request per word, and learns the direction, the memory address, the word count and a word of special-request flags.

It then moves the data. Device-to-memory commands take words from the peripheral over a valid/ready port and write them to memory. Memory-to-device commands read memory and offer each word to the peripheral. Every memory access waits for the arbiter's grant, and the request is withdrawn for at least one cycle after each grant so the host can win the bus back. When the command has finished the engine raises an interrupt and holds it until the host acknowledges it. An unknown direction code ends the command at once and sets an error flag.

Top module: `iop_engine`

## Requirements
- R1: After reset, busy, irq, err, mem_req, dev_rx_ready and dev_tx_valid are all low.
- R2: A start is taken only when start_valid is high, start_op equals 2'b01 and the engine is idle; busy then rises on the next cycle. Any other start_op value is ignored and busy stays low.
- R3: The command block is read as four memory reads at base, base+4, base+8 and base+12, in that order, holding the direction code, the memory address, the word count and the flags word.
- R4: Direction code 0 moves count words from the device to memory. Each word is taken on a dev_rx_valid/dev_rx_ready handshake and written to the current address, which then advances by 4.
- R5: Direction code 1 moves count words from memory to the device. Each word is read from the current address and offered on dev_tx_data with dev_tx_valid until dev_tx_ready; the address then advances by 4.
- R6: A memory access completes only in a cycle where mem_req and mem_gnt are both high, and mem_req is low in the cycle after every such grant.
- R7: A count of zero with a valid direction code ends the command with no data access, raises irq and leaves err low.
- R8: A direction code other than 0 or 1 ends the command with no data access, raises irq and sets err.
- R9: irq stays high until irq_ack is pulsed and falls on the cycle after the pulse. err keeps its value until the next accepted start clears it.
- R10: A start that arrives while busy is ignored: dev_sel, the command being run and the words moved are unchanged.
- R11: dev_sel shows the device address taken with the accepted start, and dev_flags shows the flags word of the command block during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Host start pulse |
| start_op | input | 2 | Host operation; 2'b01 launches a command |
| start_dev | input | DEV_W | Target peripheral address |
| start_base | input | AW | Byte address of the command block |
| busy | output | 1 | Engine is running a command |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Arbiter grant; access completes when high with mem_req |
| mem_rdata | input | DW | Read data, valid in the granted cycle |
| dev_sel | output | DEV_W | Selected peripheral |
| dev_flags | output | DW | Special-request flags from the command block |
| dev_rx_valid | input | 1 | Peripheral offers a word |
| dev_rx_ready | output | 1 | Engine takes a word |
| dev_rx_data | input | DW | Word from the peripheral |
| dev_tx_valid | output | 1 | Engine offers a word |
| dev_tx_ready | input | 1 | Peripheral takes a word |
| dev_tx_data | output | DW | Word to the peripheral |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Host acknowledge pulse |
| err | output | 1 | Last command had an unknown direction code |

## Verification
The assertions take for granted that the arbiter raises mem_gnt only while mem_req is high and that read data is valid in the granted cycle; the bench memory model grants only a live request, after a chosen delay of zero or more cycles, and returns data combinationally from its array. They also assume the peripheral holds its valid word stable until taken, which the bench device model does by advancing its queue only after a completed handshake. Host inputs are changed only on the falling edge so that no start or acknowledge straddles a sampling edge.

// File: rtl/iop_pkg.sv
package iop_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_DECODE, S_RX, S_WR, S_RD, S_TX, S_DONE
   } iop_state_e;

   localparam logic [1:0] HOST_OP_LAUNCH = 2'b01;
   localparam int         BLOCK_WORDS    = 4;
   localparam int         BLOCK_IDX_W    = $clog2(BLOCK_WORDS);
endpackage

// File: rtl/iop_walker.sv
module iop_walker #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter bit BYTE_ADDR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_addr,
   input  logic          ld_cnt,
   input  logic [DW-1:0] ld_word,
   input  logic          step,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] cur_cnt,
   output logic [AW-1:0] stride,
   output logic          is_last,
   output logic          is_zero
);
   generate
      if (BYTE_ADDR) begin : g_byte
         assign stride = AW'(DW / 8);
      end else begin : g_word
         assign stride = AW'(1);
      end
      if (AW > DW) begin : g_bad_aw
         $error("iop_walker: AW must not exceed DW");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
      end else begin
         if (ld_addr)   cur_addr <= ld_word[AW-1:0];
         else if (step) cur_addr <= cur_addr + stride;
         if (ld_cnt)    cur_cnt  <= ld_word;
         else if (step) cur_cnt  <= cur_cnt - 1'b1;
      end
   end

   assign is_last = (cur_cnt == DW'(1));
   assign is_zero = (cur_cnt == '0);

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step && !ld_cnt && !is_zero |=> cur_cnt == $past(cur_cnt) - 1'b1);
endmodule

// File: rtl/iop_irq.sv
module iop_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic fault_i,
   input  logic launch_i,
   input  logic ack_i,
   output logic irq_o,
   output logic err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         err_o <= 1'b0;
      end else begin
         if (done_i)     irq_o <= 1'b1;
         else if (ack_i) irq_o <= 1'b0;
         if (launch_i)    err_o <= 1'b0;
         else if (done_i) err_o <= fault_i;
      end
   end

   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !ack_i |=> irq_o);
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
   import iop_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   input  logic [1:0]       start_op,
   input  logic [DEV_W-1:0] start_dev,
   input  logic [AW-1:0]    start_base,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_gnt,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DEV_W-1:0] dev_sel,
   output logic [DW-1:0]    dev_flags,
   input  logic             rx_valid,
   output logic             rx_ready,
   input  logic [DW-1:0]    rx_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [DW-1:0]    tx_data,
   output logic             busy,
   output logic             walk_ld_addr,
   output logic             walk_ld_cnt,
   output logic             walk_step,
   input  logic [AW-1:0]    walk_addr,
   input  logic [AW-1:0]    walk_stride,
   input  logic             walk_last,
   input  logic             walk_zero,
   output logic             done,
   output logic             fault,
   output logic             launch
);
   iop_state_e             st;
   logic [BLOCK_IDX_W-1:0] idx;
   logic [AW-1:0]          base;
   logic [DW-1:0]          opcode;
   logic [DW-1:0]          hold;
   logic                   gap;
   logic                   grant;
   logic                   unknown_op;

   assign launch     = (st == S_IDLE) && start_valid && (start_op == HOST_OP_LAUNCH);
   assign mem_req    = ((st == S_FETCH) || (st == S_WR) || (st == S_RD)) && !gap;
   assign grant      = mem_req && mem_gnt;
   assign mem_we     = (st == S_WR);
   assign mem_addr   = (st == S_FETCH) ? base + AW'(idx) * walk_stride : walk_addr;
   assign mem_wdata  = hold;
   assign tx_data    = hold;
   assign rx_ready   = (st == S_RX);
   assign tx_valid   = (st == S_TX);
   assign busy       = (st != S_IDLE);
   assign done       = (st == S_DONE);
   assign unknown_op = (opcode[DW-1:1] != '0);
   assign fault      = unknown_op;

   assign walk_ld_addr = (st == S_FETCH) && grant && (idx == BLOCK_IDX_W'(1));
   assign walk_ld_cnt  = (st == S_FETCH) && grant && (idx == BLOCK_IDX_W'(2));
   assign walk_step    = ((st == S_WR) && grant) || ((st == S_TX) && tx_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         idx       <= '0;
         base      <= '0;
         opcode    <= '0;
         hold      <= '0;
         gap       <= 1'b0;
         dev_sel   <= '0;
         dev_flags <= '0;
      end else begin
         gap <= grant;
         case (st)
            S_IDLE: if (launch) begin
               base    <= start_base;
               dev_sel <= start_dev;
               idx     <= '0;
               st      <= S_FETCH;
            end
            S_FETCH: if (grant) begin
               if (idx == BLOCK_IDX_W'(0)) opcode <= mem_rdata;
               if (idx == BLOCK_IDX_W'(BLOCK_WORDS - 1)) begin
                  dev_flags <= mem_rdata;
                  st        <= S_DECODE;
               end
               idx <= idx + 1'b1;
            end
            S_DECODE: begin
               if (unknown_op || walk_zero) st <= S_DONE;
               else if (opcode[0])          st <= S_RD;
               else                         st <= S_RX;
            end
            S_RX: if (rx_valid) begin
               hold <= rx_data;
               st   <= S_WR;
            end
            S_WR: if (grant) st <= walk_last ? S_DONE : S_RX;
            S_RD: if (grant) begin
               hold <= mem_rdata;
               st   <= S_TX;
            end
            S_TX: if (tx_ready) st <= walk_last ? S_DONE : S_RD;
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   p_req_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt |=> !mem_req);
   p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_ready, tx_valid, mem_req}));
   p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start_valid |=> $stable(dev_sel));
   p_write_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !tx_valid && (st == S_WR));
endmodule

// File: rtl/iop_engine.sv
module iop_engine #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int DEV_W     = 4,
   parameter bit BYTE_ADDR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   input  logic [1:0]       start_op,
   input  logic [DEV_W-1:0] start_dev,
   input  logic [AW-1:0]    start_base,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_gnt,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DEV_W-1:0] dev_sel,
   output logic [DW-1:0]    dev_flags,
   input  logic             dev_rx_valid,
   output logic             dev_rx_ready,
   input  logic [DW-1:0]    dev_rx_data,
   output logic             dev_tx_valid,
   input  logic             dev_tx_ready,
   output logic [DW-1:0]    dev_tx_data,
   output logic             irq,
   input  logic             irq_ack,
   output logic             err
);
   generate
      if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
         $error("iop_engine: DW must be a multiple of 8");
      end
      if (DEV_W < 1) begin : g_bad_dev
         $error("iop_engine: DEV_W must be at least 1");
      end
   endgenerate

   logic          w_ld_addr, w_ld_cnt, w_step, w_last, w_zero;
   logic [AW-1:0] w_addr, w_stride;
   logic [DW-1:0] w_cnt;
   logic          c_done, c_fault, c_launch;

   iop_ctrl #(.AW(AW), .DW(DW), .DEV_W(DEV_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_op(start_op),
      .start_dev(start_dev), .start_base(start_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .dev_sel(dev_sel), .dev_flags(dev_flags),
      .rx_valid(dev_rx_valid), .rx_ready(dev_rx_ready), .rx_data(dev_rx_data),
      .tx_valid(dev_tx_valid), .tx_ready(dev_tx_ready), .tx_data(dev_tx_data),
      .busy(busy),
      .walk_ld_addr(w_ld_addr), .walk_ld_cnt(w_ld_cnt), .walk_step(w_step),
      .walk_addr(w_addr), .walk_stride(w_stride),
      .walk_last(w_last), .walk_zero(w_zero),
      .done(c_done), .fault(c_fault), .launch(c_launch)
   );

   iop_walker #(.AW(AW), .DW(DW), .BYTE_ADDR(BYTE_ADDR)) i_walker (
      .clk(clk), .rst_n(rst_n),
      .ld_addr(w_ld_addr), .ld_cnt(w_ld_cnt), .ld_word(mem_rdata),
      .step(w_step), .cur_addr(w_addr), .cur_cnt(w_cnt),
      .stride(w_stride), .is_last(w_last), .is_zero(w_zero)
   );

   iop_irq i_irq (
      .clk(clk), .rst_n(rst_n),
      .done_i(c_done), .fault_i(c_fault), .launch_i(c_launch),
      .ack_i(irq_ack), .irq_o(irq), .err_o(err)
   );

   p_irq_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(busy) && !busy);
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start_valid && start_op == 2'b01 |=> busy);
endmodule

// File: tb/test_iop_engine.sv
module test_iop_engine;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, DW = 32, DEV_W = 4;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             start_valid = 1'b0;
   logic [1:0]       start_op = 2'b00;
   logic [DEV_W-1:0] start_dev = '0;
   logic [AW-1:0]    start_base = '0;
   logic             busy, mem_req, mem_we, mem_gnt = 1'b0;
   logic [AW-1:0]    mem_addr;
   logic [DW-1:0]    mem_wdata, mem_rdata, dev_flags, dev_tx_data;
   logic [DEV_W-1:0] dev_sel;
   logic             dev_rx_valid = 1'b0, dev_rx_ready, dev_tx_valid, dev_tx_ready = 1'b1;
   logic [DW-1:0]    dev_rx_data = '0;
   logic             irq, irq_ack = 1'b0, err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   iop_engine #(.AW(AW), .DW(DW), .DEV_W(DEV_W)) i_iop_engine (.*);

   int checks = 0, fails = 0, cyc = 0;
   logic [31:0] mem [0:63];
   assign mem_rdata = mem[mem_addr[7:2]];

   int gnt_delay = 0, wait_c = 0, gap_viol = 0, wr_n = 0;
   logic last_grant = 1'b0;
   logic [31:0] rd_log [0:63];
   int rd_n = 0;
   logic [31:0] rx_q [0:15];
   int rx_n = 0, rx_i = 0;
   logic last_rx = 1'b0;
   logic [31:0] tx_log [0:15];
   int tx_n = 0;
   logic [31:0] flags_seen = '0;

   // memory, arbiter and device models, all updated on the falling edge
   always @(negedge clk) begin
      if (last_grant && mem_req) gap_viol++;
      if (mem_req && wait_c >= gnt_delay) mem_gnt = 1'b1;
      else mem_gnt = 1'b0;
      if (mem_req && !mem_gnt) wait_c++;
      if (!mem_req) wait_c = 0;
      last_grant = mem_req && mem_gnt;
      if (last_grant) begin
         wait_c = 0;
         if (mem_we) begin
            mem[mem_addr[7:2]] = mem_wdata;
            wr_n++;
         end else if (rd_n < 64) begin
            rd_log[rd_n] = mem_addr;
            rd_n++;
         end
      end
      if (last_rx) rx_i++;
      dev_rx_valid = (rx_i < rx_n);
      dev_rx_data  = (rx_i < rx_n) ? rx_q[rx_i] : '0;
      last_rx = dev_rx_valid && dev_rx_ready;
      if (dev_tx_valid && dev_tx_ready && tx_n < 16) begin
         tx_log[tx_n] = dev_tx_data;
         tx_n++;
         flags_seen = dev_flags;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog expired: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      rd_n = 0; wr_n = 0; tx_n = 0; rx_n = 0; rx_i = 0; gap_viol = 0; flags_seen = '0;
   endtask

   task automatic put_block(input int base, input logic [31:0] opc, input logic [31:0] addr,
                            input logic [31:0] cnt, input logic [31:0] flg);
      mem[base / 4] = opc; mem[base / 4 + 1] = addr;
      mem[base / 4 + 2] = cnt; mem[base / 4 + 3] = flg;
   endtask

   task automatic launch(input logic [1:0] op, input logic [DEV_W-1:0] dev, input logic [31:0] base);
      @(negedge clk);
      start_valid = 1'b1; start_op = op; start_dev = dev; start_base = base;
      @(negedge clk);
      start_valid = 1'b0;
   endtask

   task automatic wait_irq(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (irq) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "busy", busy, 0);
      check("R1", "irq", irq, 0);
      check("R1", "err", err, 0);
      check("R1", "mem_req", mem_req, 0);
      check("R1", "rx_ready/tx_valid", {dev_rx_ready, dev_tx_valid}, 0);
   endtask

   task automatic t_wrong_host_op();
      put_block(0, 0, 32'h80, 2, 0);
      clear_logs();
      launch(2'b10, 4'h3, 0);
      repeat (5) @(negedge clk);
      check("R2", "busy after non-launch op", busy, 0);
      check("R2", "memory reads", rd_n, 0);
   endtask

   task automatic t_dev_to_mem(input int dly);
      bit seen;
      gnt_delay = dly;
      for (int k = 0; k < 4; k++) mem[32 + k] = 32'hDEAD_0000;
      put_block(16, 0, 32'h80, 3, 32'h0000_00A5);
      clear_logs();
      rx_q[0] = 32'h1111_0001; rx_q[1] = 32'h2222_0002; rx_q[2] = 32'h3333_0003;
      rx_n = 3;
      launch(2'b01, 4'h5, 16);
      check("R2", "busy after launch", busy, 1);
      check("R11", "dev_sel", dev_sel, 4'h5);
      wait_irq(seen);
      check("R4", "irq seen", seen, 1);
      check("R4", "word 0 at 0x80", mem[32], 32'h1111_0001);
      check("R4", "word 1 at 0x84", mem[33], 32'h2222_0002);
      check("R4", "word 2 at 0x88", mem[34], 32'h3333_0003);
      check("R4", "untouched 0x8c", mem[35], 32'hDEAD_0000);
      check("R4", "write count", wr_n, 3);
      check("R6", "request kept after grant", gap_viol, 0);
      check("R11", "dev_flags", dev_flags, 32'h0000_00A5);
      check("R9", "err after good command", err, 0);
      ack();
   endtask

   task automatic t_mem_to_dev(input int dly);
      bit seen;
      gnt_delay = dly;
      mem[48] = 32'hA0A0_0000; mem[49] = 32'hB1B1_1111; mem[50] = 32'hC2C2_2222; mem[51] = 32'hD3D3_3333;
      put_block(32, 1, 32'hC0, 4, 32'h0000_5A5A);
      clear_logs();
      launch(2'b01, 4'h9, 32);
      wait_irq(seen);
      check("R5", "irq seen", seen, 1);
      check("R3", "read 0 addr", rd_log[0], 32);
      check("R3", "read 1 addr", rd_log[1], 36);
      check("R3", "read 2 addr", rd_log[2], 40);
      check("R3", "read 3 addr", rd_log[3], 44);
      check("R5", "data read addr 0", rd_log[4], 32'hC0);
      check("R5", "data read addr 3", rd_log[7], 32'hCC);
      check("R5", "tx count", tx_n, 4);
      check("R5", "tx word 0", tx_log[0], 32'hA0A0_0000);
      check("R5", "tx word 3", tx_log[3], 32'hD3D3_3333);
      check("R6", "request kept after grant", gap_viol, 0);
      check("R11", "flags during transfer", flags_seen, 32'h0000_5A5A);
      check("R11", "dev_sel", dev_sel, 4'h9);
      ack();
   endtask

   task automatic t_zero_count();
      bit seen;
      gnt_delay = 0;
      put_block(48, 1, 32'hC0, 0, 0);
      clear_logs();
      launch(2'b01, 4'h1, 48);
      wait_irq(seen);
      check("R7", "irq on zero count", seen, 1);
      check("R7", "only block reads", rd_n, 4);
      check("R7", "no device words", tx_n, 0);
      check("R7", "err low", err, 0);
      ack();
   endtask

   task automatic t_bad_opcode();
      bit seen;
      put_block(64, 7, 32'h80, 2, 0);
      clear_logs();
      rx_q[0] = 32'h7777_7777; rx_n = 1;
      launch(2'b01, 4'h2, 64);
      wait_irq(seen);
      check("R8", "irq on unknown code", seen, 1);
      check("R8", "err set", err, 1);
      check("R8", "no writes", wr_n, 0);
      check("R8", "no reads beyond block", rd_n, 4);
      rx_n = 0;
      // irq must persist without acknowledge
      repeat (6) @(negedge clk);
      check("R9", "irq held without ack", irq, 1);
      ack();
      check("R9", "irq cleared after ack", irq, 0);
      check("R9", "err kept after ack", err, 1);
   endtask

   task automatic t_busy_ignore();
      bit seen;
      gnt_delay = 1;
      put_block(80, 1, 32'hC0, 5, 0);
      put_block(96, 0, 32'hA0, 2, 0);
      for (int k = 0; k < 3; k++) mem[40 + k] = 32'h0;
      clear_logs();
      rx_q[0] = 32'h0BAD_0001; rx_q[1] = 32'h0BAD_0002; rx_n = 2;
      launch(2'b01, 4'h6, 96);
      check("R9", "err cleared by new launch", err, 0);
      repeat (3) @(negedge clk);
      launch(2'b01, 4'hC, 80);
      check("R10", "dev_sel unchanged", dev_sel, 4'h6);
      wait_irq(seen);
      check("R10", "first command finished", seen, 1);
      check("R10", "writes of first command", wr_n, 2);
      check("R10", "second word stored", mem[41], 32'h0BAD_0002);
      check("R10", "beyond count untouched", mem[42], 32'h0);
      check("R10", "second block not fetched", rd_log[0], 96);
      check("R10", "no device output", tx_n, 0);
      ack();
      repeat (10) @(negedge clk);
      check("R10", "idle after ignored start", busy, 0);
   endtask

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrong_host_op();
      t_dev_to_mem(0);
      t_dev_to_mem(2);
      t_mem_to_dev(0);
      t_mem_to_dev(3);
      t_zero_count();
      t_bad_opcode();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule